// File: doc/BRIEF.md
# Bit-Oriented Frame Receive Deframer

This block sits behind a line sampler and turns a serial bit stream that uses bit-oriented framing into tagged characters. Each received bit arrives on `bit_in` together with a one-clock `bit_en` strobe. The block hunts for the flag pattern and enters a frame when it finds one. Inside the frame it deletes the zeros that the sender inserted for transparency. It packs the remaining bits, least significant bit first, into characters of a programmable length of 5 to 8 bits.

A frame ends on a closing flag or on an abort. In both cases the block emits one end-of-frame tag record. For a flag close, the record carries the leftover bits of the last partial character and their count, plus a short-frame mark when too few complete characters were seen. For an abort, the record carries an abort mark instead. A single flag may close one frame and open the next, and two flags may share one zero. A registered sync-detect pulse follows every flag by one bit time, and a level output reports an idle line.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A flag is the bit sequence 0,1,1,1,1,1,1,0 on the line. The first flag seen moves the block from hunting into a frame (`in_frame` high). Bits between flags come out as characters, with the first received bit in `rec_data[0]`.
- R2: Inside a frame, a 0 that follows exactly five consecutive 1s is removed and does not become part of any character.
- R3: `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 bit characters. The character sits in the low bits of `rec_data` and all higher bits are 0. A plain character record has `rec_eof`, `rec_abort`, `rec_short` and `rec_resid` all 0.
- R4: A closing flag that ends a frame holding at least one data bit emits a record with `rec_eof`=1. In that record, `rec_resid` is the number of bits after the last complete character (0 to length-1), and `rec_data` holds those bits in its low positions (0 when `rec_resid` is 0).
- R5: A single flag can close one frame and open the next. Data after it forms a new frame.
- R6: Two flags that share one zero (0111111 0 111111 0) are both recognised. Each gives a sync pulse, and the empty gap between them gives no record.
- R7: Seven consecutive 1s inside a frame abort it. If any data bit had reached the character packer, the abort emits a record with `rec_eof`=1, `rec_abort`=1, and data, residue and short mark all 0. The block then returns to hunting and ignores bits until the next flag.
- R8: `line_idle` goes high once 15 consecutive 1s have been received, and drops when a 0 arrives.
- R9: An end-of-frame record from a closing flag has `rec_short`=1 exactly when the frame held fewer complete characters than `min_chars`.
- R10: `sync_det` is high for one clock, at the clock edge that takes in the first bit after a flag's final 0.
- R11: After reset all outputs are 0 and the block is hunting. Bits received before any flag produce no record.
- R12: Flags that follow each other with no data between them produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-clock strobe marking a valid line bit |
| bit_in | input | 1 | Received line bit |
| len_sel | input | 2 | Character length select (5 + value bits) |
| min_chars | input | CNT_W | Minimum complete characters for a frame that is not short |
| rec_valid | output | 1 | Record output valid, one clock |
| rec_data | output | 8 | Character bits or leftover bits |
| rec_eof | output | 1 | Record ends a frame |
| rec_resid | output | 3 | Count of leftover bits at frame end |
| rec_abort | output | 1 | Frame ended by abort |
| rec_short | output | 1 | Frame had too few characters |
| sync_det | output | 1 | Pulse one bit time after a flag |
| line_idle | output | 1 | 15 or more consecutive 1s on the line |
| in_frame | output | 1 | Block is inside a frame (not hunting) |

## Verification
The bench targets the places where a deframer usually goes wrong. It sends data bytes holding runs of five and six 1s. A design that miscounts the run would either keep the inserted zero or take real data for a flag. It sends a shared closing/opening flag and a pair of flags sharing a zero. A design that needs a fresh leading 0 would merge or drop frames and miss a sync pulse. It ends frames on a partial character and at exactly the minimum character count. A design that sends the flag's leading bits into the data, or that uses the wrong comparison for short frames, would report a wrong residue or a wrong short mark. It also checks that bits after an abort and before the next flag stay silent, and that idle is reported at the fifteenth 1 and not at the fourteenth.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    // Run lengths of consecutive ones that classify a line event
    localparam int STUFF_RUN = 5;
    localparam int FLAG_RUN  = 6;
    localparam int ABORT_RUN = 7;
    localparam int IDLE_RUN  = 15;

    // Flag spans FLAG_RUN+2 line bits; all but the last enter the data path
    localparam int FLAG_LEN  = FLAG_RUN + 2;
    localparam int HOLD_BITS = FLAG_LEN - 1;

    localparam int CHAR_MAX  = 8;
    localparam int CHAR_MIN  = 5;
    localparam int RESID_W   = $clog2(CHAR_MAX);

    typedef enum logic [2:0] {
        EV_NONE,
        EV_DATA,
        EV_STUFF,
        EV_FLAG,
        EV_ABORT,
        EV_IDLE
    } line_ev_e;

    typedef struct packed {
        line_ev_e ev;
        logic     bit_val;
    } line_sym_t;

    typedef enum logic {
        FR_HUNT,
        FR_OPEN
    } frame_st_e;

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                eof;
        logic [RESID_W-1:0]  resid;
        logic                aborted;
        logic                short_fr;
    } rx_rec_t;

    function automatic logic [3:0] char_bits(input logic [1:0] sel);
        return 4'(CHAR_MIN) + {2'b00, sel};
    endfunction

endpackage

// File: rtl/hdlc_rx_linemon.sv
module hdlc_rx_linemon
    import hdlc_rx_pkg::*;
#(
    parameter int RUN_MAX = IDLE_RUN
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_en,
    input  logic      bit_in,
    output line_sym_t sym,
    output logic      line_idle
);
    localparam int RW = $clog2(RUN_MAX + 1);

    logic [RW-1:0] run_q;
    logic [RW-1:0] run_inc;

    always_comb begin
        run_inc     = (run_q == RW'(RUN_MAX)) ? run_q : run_q + 1'b1;
        sym.bit_val = bit_in;
        sym.ev      = EV_NONE;
        if (bit_in) begin
            if (run_q < RW'(ABORT_RUN - 1))
                sym.ev = EV_DATA;
            else if (run_q == RW'(ABORT_RUN - 1))
                sym.ev = EV_ABORT;
            else if (run_q == RW'(RUN_MAX - 1))
                sym.ev = EV_IDLE;
        end else begin
            if (run_q == RW'(FLAG_RUN))
                sym.ev = EV_FLAG;
            else if (run_q == RW'(STUFF_RUN))
                sym.ev = EV_STUFF;
            else if (run_q < RW'(STUFF_RUN))
                sym.ev = EV_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (bit_en)
            run_q <= bit_in ? run_inc : '0;
    end

    assign line_idle = (run_q == RW'(RUN_MAX));

endmodule

// File: rtl/hdlc_rx_delay.sv
module hdlc_rx_delay #(
    parameter int DEPTH = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic push_bit,
    input  logic flush,
    output logic rel_valid,
    output logic rel_bit
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] sr_q;
    logic [CW-1:0]    cnt_q;

    // Oldest held bit leaves only once the line is DEPTH bits past it
    assign rel_valid = push && (cnt_q == CW'(DEPTH));
    assign rel_bit   = sr_q[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            cnt_q <= '0;
        end else if (push) begin
            sr_q <= {sr_q[DEPTH-2:0], push_bit};
            if (cnt_q != CW'(DEPTH))
                cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler
    import hdlc_rx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             frame_end,
    input  logic             frame_abort,
    input  logic [1:0]       len_sel,
    input  logic [CNT_W-1:0] min_chars,
    output rx_rec_t          rec,
    output logic             rec_valid
);
    localparam int IDX_W = RESID_W;

    logic [CHAR_MAX-1:0] acc_q;
    logic [CHAR_MAX-1:0] acc_ins;
    logic [IDX_W-1:0]    idx_q;
    logic [CNT_W-1:0]    nchar_q;
    logic [3:0]          len;
    logic                last_bit;
    logic                has_bits;

    always_comb begin
        len          = char_bits(len_sel);
        acc_ins      = acc_q;
        acc_ins[idx_q] = in_bit;
        last_bit     = ({1'b0, idx_q} == (len - 4'd1));
        has_bits     = (nchar_q != '0) || (idx_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            idx_q     <= '0;
            nchar_q   <= '0;
            rec       <= '0;
            rec_valid <= 1'b0;
        end else begin
            rec_valid <= 1'b0;
            if (frame_end || frame_abort) begin
                if (has_bits) begin
                    rec_valid    <= 1'b1;
                    rec.data     <= frame_abort ? '0 : acc_q;
                    rec.eof      <= 1'b1;
                    rec.resid    <= frame_abort ? '0 : idx_q;
                    rec.aborted  <= frame_abort;
                    rec.short_fr <= !frame_abort && (nchar_q < min_chars);
                end
                acc_q   <= '0;
                idx_q   <= '0;
                nchar_q <= '0;
            end else if (in_valid) begin
                if (last_bit) begin
                    rec_valid    <= 1'b1;
                    rec.data     <= acc_ins;
                    rec.eof      <= 1'b0;
                    rec.resid    <= '0;
                    rec.aborted  <= 1'b0;
                    rec.short_fr <= 1'b0;
                    acc_q        <= '0;
                    idx_q        <= '0;
                    if (nchar_q != '1)
                        nchar_q <= nchar_q + 1'b1;
                end else begin
                    acc_q <= acc_ins;
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_en,
    input  logic                bit_in,
    input  logic [1:0]          len_sel,
    input  logic [CNT_W-1:0]    min_chars,
    output logic                rec_valid,
    output logic [CHAR_MAX-1:0] rec_data,
    output logic                rec_eof,
    output logic [RESID_W-1:0]  rec_resid,
    output logic                rec_abort,
    output logic                rec_short,
    output logic                sync_det,
    output logic                line_idle,
    output logic                in_frame
);
    line_sym_t sym;
    frame_st_e st_q;
    rx_rec_t   rec;
    logic      is_flag;
    logic      is_abort;
    logic      open_fr;
    logic      push;
    logic      flush;
    logic      rel_valid;
    logic      rel_bit;
    logic      sync_pend_q;

    hdlc_rx_linemon #(.RUN_MAX(IDLE_RUN)) u_linemon (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .sym       (sym),
        .line_idle (line_idle)
    );

    assign open_fr  = (st_q == FR_OPEN);
    assign is_flag  = bit_en && (sym.ev == EV_FLAG);
    assign is_abort = bit_en && (sym.ev == EV_ABORT);
    assign push     = open_fr && bit_en && (sym.ev == EV_DATA);
    assign flush    = is_flag || (open_fr && is_abort);

    hdlc_rx_delay #(.DEPTH(HOLD_BITS)) u_delay (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_bit  (sym.bit_val),
        .flush     (flush),
        .rel_valid (rel_valid),
        .rel_bit   (rel_bit)
    );

    hdlc_rx_assembler #(.CNT_W(CNT_W)) u_asm (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (rel_valid),
        .in_bit      (rel_bit),
        .frame_end   (open_fr && is_flag),
        .frame_abort (open_fr && is_abort),
        .len_sel     (len_sel),
        .min_chars   (min_chars),
        .rec         (rec),
        .rec_valid   (rec_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= FR_HUNT;
            sync_pend_q <= 1'b0;
            sync_det    <= 1'b0;
        end else begin
            if (is_flag)
                st_q <= FR_OPEN;
            else if (is_abort)
                st_q <= FR_HUNT;
            sync_det <= bit_en && sync_pend_q;
            if (is_flag)
                sync_pend_q <= 1'b1;
            else if (bit_en)
                sync_pend_q <= 1'b0;
        end
    end

    assign in_frame  = open_fr;
    assign rec_data  = rec.data;
    assign rec_eof   = rec.eof;
    assign rec_resid = rec.resid;
    assign rec_abort = rec.aborted;
    assign rec_short = rec.short_fr;

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk
    import hdlc_rx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bit_en,
    input logic [1:0]          len_sel,
    input logic                rec_valid,
    input logic [CHAR_MAX-1:0] rec_data,
    input logic                rec_eof,
    input logic [RESID_W-1:0]  rec_resid,
    input logic                rec_abort,
    input logic                rec_short,
    input logic                sync_det,
    input logic                line_idle,
    input logic                in_frame
);
    logic [3:0] len;
    assign len = char_bits(len_sel);

    p_rec_after_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $past(bit_en));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_eof) |-> ((rec_data >> len) == '0));

    p_plain_char_r3: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_eof) |-> (!rec_short && !rec_abort && rec_resid == '0));

    p_resid_below_len_r4: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_eof) |-> ({1'b0, rec_resid} < len));

    p_abort_tag_r7: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_abort) |-> (rec_eof && rec_resid == '0 && !rec_short && !in_frame));

    p_idle_hunting_r8: assert property (@(posedge clk) disable iff (rst)
        line_idle |-> !in_frame);

    p_sync_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        sync_det |-> $past(bit_en));

    p_sync_single_r10: assert property (@(posedge clk) disable iff (rst)
        sync_det |=> !sync_det);

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .len_sel   (len_sel),
    .rec_valid (rec_valid),
    .rec_data  (rec_data),
    .rec_eof   (rec_eof),
    .rec_resid (rec_resid),
    .rec_abort (rec_abort),
    .rec_short (rec_short),
    .sync_det  (sync_det),
    .line_idle (line_idle),
    .in_frame  (in_frame)
);

// File: tb/hdlc_rx_deframer_test.sv
module hdlc_rx_deframer_test;

    localparam int CLK_PERIOD      = 10;
    localparam int WATCHDOG_CYCLES = 100000;
    localparam int LOG_MAX         = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic [1:0] len_sel = 2'd3;
    logic [3:0] min_chars = 4'd1;

    logic       rec_valid;
    logic [7:0] rec_data;
    logic       rec_eof;
    logic [2:0] rec_resid;
    logic       rec_abort;
    logic       rec_short;
    logic       sync_det;
    logic       line_idle;
    logic       in_frame;

    int checks = 0;
    int fails  = 0;
    int bits_sent = 0;
    int tx_ones = 0;

    logic [13:0] m_rec [LOG_MAX];
    int m_n = 0;
    int sync_cnt = 0;
    int sync_last = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_deframer #(.CNT_W(4)) uut (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .len_sel   (len_sel),
        .min_chars (min_chars),
        .rec_valid (rec_valid),
        .rec_data  (rec_data),
        .rec_eof   (rec_eof),
        .rec_resid (rec_resid),
        .rec_abort (rec_abort),
        .rec_short (rec_short),
        .sync_det  (sync_det),
        .line_idle (line_idle),
        .in_frame  (in_frame)
    );

    // Record log: {data, eof, resid, abort, short}
    always @(negedge clk) begin
        if (!rst) begin
            if (rec_valid && m_n < LOG_MAX) begin
                m_rec[m_n] = {rec_data, rec_eof, rec_resid, rec_abort, rec_short};
                m_n = m_n + 1;
            end
            if (sync_det) begin
                sync_cnt  = sync_cnt + 1;
                sync_last = bits_sent;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tx_ones = 0;
        bits_sent = 0;
    endtask

    task automatic tick_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(posedge clk);
        bits_sent++;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_flag();
        tick_bit(1'b0);
        for (int i = 0; i < 6; i++) tick_bit(1'b1);
        tick_bit(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) tick_bit(1'b1);
        tx_ones = 0;
    endtask

    task automatic send_data(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            tick_bit(v[i]);
            if (v[i]) begin
                tx_ones++;
                if (tx_ones == 5) begin
                    tick_bit(1'b0);
                    tx_ones = 0;
                end
            end else begin
                tx_ones = 0;
            end
        end
    endtask

    task automatic chk_count(input int base, input int n, input string req);
        chk((m_n - base) == n, req, "record count", m_n - base, n);
    endtask

    task automatic chk_rec(input int idx, input logic [7:0] d, input logic eof,
                           input logic [2:0] resid, input logic ab, input logic sh,
                           input string req);
        logic [13:0] exp;
        exp = {d, eof, resid, ab, sh};
        if (idx >= m_n)
            chk(1'b0, req, "missing record {data,eof,resid,abort,short}", 0, int'(exp));
        else
            chk(m_rec[idx] == exp, req, "record {data,eof,resid,abort,short}",
                int'(m_rec[idx]), int'(exp));
    endtask

    // R11: reset state and bits before any flag
    task automatic t_reset_hunt();
        int base;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk({rec_valid, rec_data, rec_eof, rec_resid, rec_abort, rec_short,
             sync_det, line_idle, in_frame} == '0, "R11", "outputs in reset",
            int'({rec_valid, sync_det, line_idle, in_frame}), 0);
        do_reset();
        base = m_n;
        len_sel = 2'd3;
        send_data(16'hA53C, 16);
        settle();
        chk_count(base, 0, "R11");
        chk(in_frame == 1'b0, "R11", "in_frame before flag", int'(in_frame), 0);
    endtask

    // R1 R4 R9: two bytes, count equal to minimum is not short
    task automatic t_basic();
        int base;
        do_reset();
        len_sel = 2'd3;
        min_chars = 4'd2;
        base = m_n;
        send_flag();
        settle();
        chk(in_frame == 1'b1, "R1", "in_frame after flag", int'(in_frame), 1);
        send_data(16'h00A5, 8);
        send_data(16'h003C, 8);
        send_flag();
        settle();
        chk_count(base, 3, "R1");
        chk_rec(base + 0, 8'hA5, 0, 0, 0, 0, "R1");
        chk_rec(base + 1, 8'h3C, 0, 0, 0, 0, "R1");
        chk_rec(base + 2, 8'h00, 1, 0, 0, 0, "R4 R9");
    endtask

    // R2: data containing runs of ones that force zero insertion
    task automatic t_stuffing();
        int base;
        do_reset();
        len_sel = 2'd3;
        min_chars = 4'd1;
        base = m_n;
        send_flag();
        send_data(16'h00FF, 8);
        send_data(16'h007E, 8);
        send_data(16'h003E, 8);
        send_flag();
        settle();
        chk_count(base, 4, "R2");
        chk_rec(base + 0, 8'hFF, 0, 0, 0, 0, "R2");
        chk_rec(base + 1, 8'h7E, 0, 0, 0, 0, "R2");
        chk_rec(base + 2, 8'h3E, 0, 0, 0, 0, "R2");
        chk_rec(base + 3, 8'h00, 1, 0, 0, 0, "R2");
    endtask

    // R3: five and six bit characters
    task automatic t_length();
        int base;
        do_reset();
        len_sel = 2'd0;
        min_chars = 4'd1;
        base = m_n;
        send_flag();
        send_data(16'h02B3, 10);
        send_flag();
        settle();
        chk_count(base, 3, "R3");
        chk_rec(base + 0, 8'h13, 0, 0, 0, 0, "R3");
        chk_rec(base + 1, 8'h15, 0, 0, 0, 0, "R3");
        chk_rec(base + 2, 8'h00, 1, 0, 0, 0, "R3");
        len_sel = 2'd2;
        base = m_n;
        send_data(16'h3FFF, 14);
        send_flag();
        settle();
        chk_rec(base + 0, 8'h7F, 0, 0, 0, 0, "R3");
        chk_rec(base + 1, 8'h7F, 0, 0, 0, 0, "R3");
        len_sel = 2'd3;
    endtask

    // R4 R9: partial final character and short frame
    task automatic t_residual();
        int base;
        do_reset();
        len_sel = 2'd3;
        min_chars = 4'd2;
        base = m_n;
        send_flag();
        send_data(16'h00C3, 8);
        send_data(16'h0005, 3);
        send_flag();
        settle();
        chk_count(base, 2, "R4");
        chk_rec(base + 0, 8'hC3, 0, 0, 0, 0, "R4");
        chk_rec(base + 1, 8'h05, 1, 3, 0, 1, "R4 R9");
        min_chars = 4'd1;
    endtask

    // R5: one flag closes a frame and opens the next
    task automatic t_shared_flag();
        int base;
        do_reset();
        len_sel = 2'd3;
        min_chars = 4'd1;
        base = m_n;
        send_flag();
        send_data(16'h0081, 8);
        send_flag();
        send_data(16'h9942, 16);
        send_flag();
        settle();
        chk_count(base, 5, "R5");
        chk_rec(base + 0, 8'h81, 0, 0, 0, 0, "R5");
        chk_rec(base + 1, 8'h00, 1, 0, 0, 0, "R5");
        chk_rec(base + 2, 8'h42, 0, 0, 0, 0, "R5");
        chk_rec(base + 3, 8'h99, 0, 0, 0, 0, "R5");
        chk_rec(base + 4, 8'h00, 1, 0, 0, 0, "R5");
    endtask

    // R6: two flags sharing one zero
    task automatic t_overlap();
        int base;
        int sbase;
        do_reset();
        len_sel = 2'd3;
        base = m_n;
        sbase = sync_cnt;
        send_flag();
        send_ones(6);
        tick_bit(1'b0);
        send_data(16'h0055, 8);
        send_flag();
        tick_bit(1'b1);
        settle();
        chk((sync_cnt - sbase) == 3, "R6", "sync pulses", sync_cnt - sbase, 3);
        chk_count(base, 2, "R6");
        chk_rec(base + 0, 8'h55, 0, 0, 0, 0, "R6");
        chk_rec(base + 1, 8'h00, 1, 0, 0, 0, "R6");
    endtask

    // R7: abort in a frame, then silence until the next flag
    task automatic t_abort();
        int base;
        do_reset();
        len_sel = 2'd3;
        base = m_n;
        send_flag();
        send_data(16'h0012, 8);
        send_data(16'h0000, 2);
        send_ones(7);
        settle();
        chk(in_frame == 1'b0, "R7", "in_frame after abort", int'(in_frame), 0);
        tick_bit(1'b0);
        send_data(16'hA5A5, 16);
        settle();
        chk_count(base, 2, "R7");
        chk_rec(base + 0, 8'h12, 0, 0, 0, 0, "R7");
        chk_rec(base + 1, 8'h00, 1, 0, 1, 0, "R7");
    endtask

    // R8: idle reported at fifteen ones, not fourteen
    task automatic t_idle();
        do_reset();
        send_ones(14);
        settle();
        chk(line_idle == 1'b0, "R8", "line_idle after 14 ones", int'(line_idle), 0);
        send_ones(1);
        settle();
        chk(line_idle == 1'b1, "R8", "line_idle after 15 ones", int'(line_idle), 1);
        tick_bit(1'b0);
        settle();
        chk(line_idle == 1'b0, "R8", "line_idle after zero", int'(line_idle), 0);
    endtask

    // R10: sync pulse timing
    task automatic t_sync();
        int sbase;
        do_reset();
        sbase = sync_cnt;
        send_flag();
        settle();
        chk((sync_cnt - sbase) == 0, "R10", "sync before next bit", sync_cnt - sbase, 0);
        tick_bit(1'b1);
        settle();
        chk((sync_cnt - sbase) == 1, "R10", "sync count", sync_cnt - sbase, 1);
        chk(sync_last == 9, "R10", "sync bit index", sync_last, 9);
    endtask

    // R12: back-to-back flags
    task automatic t_empty();
        int base;
        do_reset();
        base = m_n;
        send_flag();
        send_flag();
        send_flag();
        settle();
        chk_count(base, 0, "R12");
        chk(in_frame == 1'b1, "R12", "in_frame after flags", int'(in_frame), 1);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_hunt();
        t_basic();
        t_stuffing();
        t_length();
        t_residual();
        t_shared_flag();
        t_overlap();
        t_abort();
        t_idle();
        t_sync();
        t_empty();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule